// File: doc/BRIEF.md
# I2C Master Bus-Side Register and Queue Front End

This block is the processor-facing half of an I2C master peripheral. It answers 32-bit APB accesses at four word addresses: one location feeds a transmit queue, one drains a receive queue, one holds a control word and one holds a start-delay count. A separate serial engine, not part of this block, takes bytes from the transmit queue and pushes received data into the receive queue. It also reads the operation selection, the clock-divider setting and the start delay that software has programmed.

Software writes the control word to choose a transmit or a receive operation and to set the divider. It writes the delay register, then fills the transmit queue or empties the receive queue. Two interrupt lines tell software when the transmit queue has run dry and when received data is waiting. Every access completes without wait states. The error response flags illegal or impossible accesses.

Top module: `i2cm_apb_frontend`

## Requirements
- R1: After reset both queues are empty, the control word and the delay register read as zero, `irq_tx_empty` is high and `irq_rx_avail` is low.
- R2: `apb_ready` is high exactly in the access cycle (`apb_sel` and `apb_enable` both high) and low otherwise; `apb_err` is low outside the access cycle.
- R3: A write to byte address 0 stores `apb_wdata` into the transmit queue in the access cycle only; a setup cycle alone changes nothing. The engine sees entries on `tx_data` in write order and removes the head with `tx_pop`.
- R4: A write to address 0 while the transmit queue holds its full depth returns `apb_err` high, and the data is discarded.
- R5: A read of address 4 returns the oldest receive-queue entry on `apb_rdata` and removes it, in push order.
- R6: A read of address 4 with an empty receive queue returns zero with `apb_err` high.
- R7: Address 8 is a read/write control word. Bits [31:2] drive `clk_divider`. Bits [1:0] select the operation: 2'b01 raises `xmit_en`, 2'b10 raises `recv_en`, and 2'b00 or 2'b11 raise neither.
- R8: Address 12 is a 32-bit read/write start-delay register driven on `start_delay`.
- R9: An access to any other address (including misaligned ones), a write to address 4 or a read of address 0 returns `apb_err` high with `apb_rdata` zero and changes no state.
- R10: `irq_tx_empty` is high while the transmit queue is empty; `irq_rx_avail` is high while the receive queue holds data.
- R11: An engine push into a full receive queue (`rx_full` high) is dropped. A `tx_pop` with the transmit queue empty (`tx_empty` high) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| apb_sel | input | 1 | Slave select |
| apb_enable | input | 1 | Access-phase strobe |
| apb_write | input | 1 | 1 = write, 0 = read |
| apb_addr | input | ADDR_W | Byte address |
| apb_wdata | input | 32 | Write data |
| apb_rdata | output | 32 | Read data, valid in the access cycle |
| apb_ready | output | 1 | Transfer complete |
| apb_err | output | 1 | Error response |
| irq_tx_empty | output | 1 | Transmit queue empty interrupt |
| irq_rx_avail | output | 1 | Receive data available interrupt |
| tx_pop | input | 1 | Engine removes transmit head |
| tx_data | output | 32 | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Engine stores received word |
| rx_wdata | input | 32 | Received word |
| rx_full | output | 1 | Receive queue full |
| xmit_en | output | 1 | Transmit operation selected |
| recv_en | output | 1 | Receive operation selected |
| clk_divider | output | 30 | Divider setting for the engine |
| start_delay | output | 32 | Cycles to wait before a transfer |

## Verification
A seeded random mix of bus writes and reads, engine pops and pushes, control and delay updates, and illegal accesses runs against queue and register models in the bench. Long runs of one operation kind drive each queue to full and to empty, so the error responses and the dropped pushes are told apart from normal traffic. Directed cases cover the values 2'b00 and 2'b11 of the operation field, setup-only cycles, misaligned and out-of-range addresses, and the wrong-direction accesses to the queue locations. For each of these the bench then reads back the state that an access might have disturbed.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int BUS_W = 32;
    localparam int DIV_W = BUS_W - 2;

    localparam logic [BUS_W-1:0] OFS_TXQ = 32'd0;
    localparam logic [BUS_W-1:0] OFS_RXQ = 32'd4;
    localparam logic [BUS_W-1:0] OFS_CFG = 32'd8;
    localparam logic [BUS_W-1:0] OFS_TMO = 32'd12;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_XMIT = 2'b01,
        OP_RECV = 2'b10,
        OP_BAD  = 2'b11
    } op_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0] divider;
        op_sel_e          op;
    } ctrl_word_t;

    typedef enum logic [2:0] {
        LOC_TXQ,
        LOC_RXQ,
        LOC_CFG,
        LOC_TMO,
        LOC_NONE
    } loc_e;

    typedef struct packed {
        logic tx_push;
        logic rx_pop;
        logic cfg_we;
        logic tmo_we;
    } strobes_t;

    function automatic loc_e map_offset(input logic [BUS_W-1:0] a);
        loc_e r;
        if (a == OFS_TXQ)      r = LOC_TXQ;
        else if (a == OFS_RXQ) r = LOC_RXQ;
        else if (a == OFS_CFG) r = LOC_CFG;
        else if (a == OFS_TMO) r = LOC_TMO;
        else                   r = LOC_NONE;
        return r;
    endfunction

endpackage

// File: rtl/i2cf_sync_fifo.sv
module i2cf_sync_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/i2cf_access_decode.sv
module i2cf_access_decode
    import i2cf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              sel,
    input  logic              enable,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic [BUS_W-1:0]  rx_head,
    input  ctrl_word_t        cfg_q,
    input  logic [BUS_W-1:0]  tmo_q,
    output logic              ready,
    output logic              err,
    output logic [BUS_W-1:0]  rdata,
    output strobes_t          stb
);
    logic [BUS_W-1:0] addr_ext;
    loc_e             loc;
    logic             access;

    assign addr_ext = BUS_W'(addr);
    assign loc      = map_offset(addr_ext);
    assign access   = sel && enable;

    always_comb begin
        ready = access;
        err   = 1'b0;
        rdata = '0;
        stb   = '0;
        if (access) begin
            case (loc)
                LOC_TXQ: begin
                    if (!write || tx_full) err = 1'b1;
                    else                   stb.tx_push = 1'b1;
                end
                LOC_RXQ: begin
                    if (write || rx_empty) begin
                        err = 1'b1;
                    end else begin
                        rdata      = rx_head;
                        stb.rx_pop = 1'b1;
                    end
                end
                LOC_CFG: begin
                    if (write) stb.cfg_we = 1'b1;
                    else       rdata = cfg_q;
                end
                LOC_TMO: begin
                    if (write) stb.tmo_we = 1'b1;
                    else       rdata = tmo_q;
                end
                default: err = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/i2cf_ctrl_regs.sv
module i2cf_ctrl_regs
    import i2cf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             tmo_we,
    input  logic [BUS_W-1:0] wdata,
    output ctrl_word_t       cfg_q,
    output logic [BUS_W-1:0] tmo_q,
    output logic             xmit_en,
    output logic             recv_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            tmo_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= ctrl_word_t'(wdata);
            if (tmo_we) tmo_q <= wdata;
        end
    end

    assign xmit_en = (cfg_q.op == OP_XMIT);
    assign recv_en = (cfg_q.op == OP_RECV);

endmodule

// File: rtl/i2cm_apb_frontend.sv
module i2cm_apb_frontend
    import i2cf_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apb_sel,
    input  logic              apb_enable,
    input  logic              apb_write,
    input  logic [ADDR_W-1:0] apb_addr,
    input  logic [31:0]       apb_wdata,
    output logic [31:0]       apb_rdata,
    output logic              apb_ready,
    output logic              apb_err,
    output logic              irq_tx_empty,
    output logic              irq_rx_avail,
    input  logic              tx_pop,
    output logic [31:0]       tx_data,
    output logic              tx_empty,
    input  logic              rx_push,
    input  logic [31:0]       rx_wdata,
    output logic              rx_full,
    output logic              xmit_en,
    output logic              recv_en,
    output logic [29:0]       clk_divider,
    output logic [31:0]       start_delay
);
    logic             rst;
    logic             tx_full_w, rx_empty_w;
    logic [BUS_W-1:0] rx_head;
    ctrl_word_t       cfg_q;
    logic [BUS_W-1:0] tmo_q;
    strobes_t         stb;

    assign rst = !rst_n;

    i2cf_access_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel      (apb_sel),
        .enable   (apb_enable),
        .write    (apb_write),
        .addr     (apb_addr),
        .tx_full  (tx_full_w),
        .rx_empty (rx_empty_w),
        .rx_head  (rx_head),
        .cfg_q    (cfg_q),
        .tmo_q    (tmo_q),
        .ready    (apb_ready),
        .err      (apb_err),
        .rdata    (apb_rdata),
        .stb      (stb)
    );

    i2cf_sync_fifo #(.WIDTH(BUS_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .push      (stb.tx_push),
        .push_data (apb_wdata),
        .pop       (tx_pop),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full_w)
    );

    i2cf_sync_fifo #(.WIDTH(BUS_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_data (rx_wdata),
        .pop       (stb.rx_pop),
        .head      (rx_head),
        .empty     (rx_empty_w),
        .full      (rx_full)
    );

    i2cf_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (stb.cfg_we),
        .tmo_we  (stb.tmo_we),
        .wdata   (apb_wdata),
        .cfg_q   (cfg_q),
        .tmo_q   (tmo_q),
        .xmit_en (xmit_en),
        .recv_en (recv_en)
    );

    assign clk_divider  = cfg_q.divider;
    assign start_delay  = tmo_q;
    assign irq_tx_empty = tx_empty;
    assign irq_rx_avail = !rx_empty_w;

endmodule

// File: rtl/i2cm_apb_frontend_chk.sv
module i2cm_apb_frontend_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              apb_sel,
    input logic              apb_enable,
    input logic              apb_write,
    input logic [ADDR_W-1:0] apb_addr,
    input logic [31:0]       apb_wdata,
    input logic [31:0]       apb_rdata,
    input logic              apb_ready,
    input logic              apb_err,
    input logic              irq_tx_empty,
    input logic              irq_rx_avail,
    input logic              rx_full,
    input logic              xmit_en,
    input logic              recv_en,
    input logic [29:0]       clk_divider,
    input logic [31:0]       start_delay
);
    logic [31:0] a32;
    logic        acc, known;
    assign a32   = 32'(apb_addr);
    assign acc   = apb_sel && apb_enable;
    assign known = (a32 == 32'd0) || (a32 == 32'd4) || (a32 == 32'd8) || (a32 == 32'd12);

    // R2
    a_r2_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        apb_ready |-> acc);
    a_r2_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (!apb_ready && !apb_err));

    // R3, R10
    a_r3_push_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && apb_write && a32 == 32'd0 && !apb_err) |=> !irq_tx_empty);

    // R6
    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !apb_write && a32 == 32'd4 && !irq_rx_avail) |-> (apb_err && apb_rdata == 32'd0));

    // R7
    a_r7_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && apb_write && a32 == 32'd8) |=>
        (clk_divider == $past(apb_wdata[31:2]) &&
         xmit_en == ($past(apb_wdata[1:0]) == 2'b01) &&
         recv_en == ($past(apb_wdata[1:0]) == 2'b10)));

    // R8
    a_r8_delay_store: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && apb_write && a32 == 32'd12) |=> (start_delay == $past(apb_wdata)));

    // R9
    a_r9_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !known) |-> (apb_err && apb_rdata == 32'd0));

    // R7 operation enables are exclusive
    a_r7_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(xmit_en && recv_en));

    // R10, R11
    a_r11_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> irq_rx_avail);

endmodule

bind i2cm_apb_frontend i2cm_apb_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .apb_sel      (apb_sel),
    .apb_enable   (apb_enable),
    .apb_write    (apb_write),
    .apb_addr     (apb_addr),
    .apb_wdata    (apb_wdata),
    .apb_rdata    (apb_rdata),
    .apb_ready    (apb_ready),
    .apb_err      (apb_err),
    .irq_tx_empty (irq_tx_empty),
    .irq_rx_avail (irq_rx_avail),
    .rx_full      (rx_full),
    .xmit_en      (xmit_en),
    .recv_en      (recv_en),
    .clk_divider  (clk_divider),
    .start_delay  (start_delay)
);

// File: tb/i2cm_apb_frontend_tb.sv
module i2cm_apb_frontend_tb;
    localparam int PERIOD = 10;
    localparam int TXD    = 4;
    localparam int RXD    = 4;
    localparam int SEED   = 20240517;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        apb_sel, apb_enable, apb_write;
    logic [31:0] apb_addr, apb_wdata;
    logic [31:0] apb_rdata;
    logic        apb_ready, apb_err;
    logic        irq_tx_empty, irq_rx_avail;
    logic        tx_pop;
    logic [31:0] tx_data;
    logic        tx_empty;
    logic        rx_push;
    logic [31:0] rx_wdata;
    logic        rx_full;
    logic        xmit_en, recv_en;
    logic [29:0] clk_divider;
    logic [31:0] start_delay;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [31:0] cfg_m = '0;
    logic [31:0] tmo_m = '0;

    always #(PERIOD/2) clk = !clk;

    i2cm_apb_frontend #(.ADDR_W(32), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
        .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(apb_rdata),
        .apb_ready(apb_ready), .apb_err(apb_err),
        .irq_tx_empty(irq_tx_empty), .irq_rx_avail(irq_rx_avail),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_full(rx_full),
        .xmit_en(xmit_en), .recv_en(recv_en),
        .clk_divider(clk_divider), .start_delay(start_delay)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_xmit(input logic [31:0] c);
        return c[1:0] == 2'b01;
    endfunction
    function automatic logic exp_recv(input logic [31:0] c);
        return c[1:0] == 2'b10;
    endfunction

    task automatic bus_op(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er, output logic rdy,
                          output logic setup_rdy);
        @(negedge clk);
        apb_sel = 1'b1; apb_enable = 1'b0; apb_write = wr; apb_addr = a; apb_wdata = d;
        #(PERIOD/4);
        setup_rdy = apb_ready;
        @(negedge clk);
        apb_enable = 1'b1;
        #(PERIOD/4);
        rd = apb_rdata; er = apb_err; rdy = apb_ready;
        @(posedge clk);
        #1;
        apb_sel = 1'b0; apb_enable = 1'b0;
    endtask

    task automatic check_flags(input string req);
        #1;
        chk(req, {31'd0, irq_tx_empty}, {31'd0, txq.size() == 0});
        chk(req, {31'd0, irq_rx_avail}, {31'd0, rxq.size() != 0});
        chk(req, {31'd0, rx_full}, {31'd0, rxq.size() == RXD});
    endtask

    task automatic do_tx_write(input logic [31:0] d);
        logic [31:0] rd; logic er, rdy, srdy, exp_err;
        exp_err = (txq.size() == TXD);
        bus_op(1'b1, 32'd0, d, rd, er, rdy, srdy);
        chk(exp_err ? "R4 full write err" : "R3 write err", {31'd0, er}, {31'd0, exp_err});
        chk("R2 ready", {30'd0, srdy, rdy}, 32'd1);
        if (!exp_err) txq.push_back(d);
    endtask

    task automatic do_rx_read();
        logic [31:0] rd; logic er, rdy, srdy;
        logic [31:0] exp_d; logic exp_err;
        exp_err = (rxq.size() == 0);
        exp_d   = exp_err ? 32'd0 : rxq[0];
        bus_op(1'b0, 32'd4, 32'd0, rd, er, rdy, srdy);
        chk(exp_err ? "R6 empty read data" : "R5 read data", rd, exp_d);
        chk(exp_err ? "R6 empty read err" : "R5 read err", {31'd0, er}, {31'd0, exp_err});
        if (!exp_err) void'(rxq.pop_front());
    endtask

    task automatic do_eng_pop();
        @(negedge clk);
        if (txq.size() != 0) begin
            chk("R3 tx head", tx_data, txq[0]);
            void'(txq.pop_front());
        end else begin
            chk("R11 tx_empty", {31'd0, tx_empty}, 32'd1);
        end
        tx_pop = 1'b1;
        @(posedge clk);
        #1 tx_pop = 1'b0;
    endtask

    task automatic do_eng_push(input logic [31:0] d);
        @(negedge clk);
        chk("R11 rx_full", {31'd0, rx_full}, {31'd0, rxq.size() == RXD});
        rx_push = 1'b1; rx_wdata = d;
        @(posedge clk);
        #1 rx_push = 1'b0;
        if (rxq.size() < RXD) rxq.push_back(d);
    endtask

    task automatic do_reg_write(input logic [31:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er, rdy, srdy;
        bus_op(1'b1, a, d, rd, er, rdy, srdy);
        chk(a == 32'd8 ? "R7 cfg write err" : "R8 delay write err", {31'd0, er}, 32'd0);
        if (a == 32'd8) cfg_m = d; else tmo_m = d;
        #1;
        chk("R7 divider", {2'b00, clk_divider}, {2'b00, cfg_m[31:2]});
        chk("R7 op enables", {30'd0, xmit_en, recv_en}, {30'd0, exp_xmit(cfg_m), exp_recv(cfg_m)});
        chk("R8 start_delay", start_delay, tmo_m);
    endtask

    task automatic do_reg_read(input logic [31:0] a);
        logic [31:0] rd; logic er, rdy, srdy;
        bus_op(1'b0, a, 32'd0, rd, er, rdy, srdy);
        chk(a == 32'd8 ? "R7 cfg read" : "R8 delay read", rd, a == 32'd8 ? cfg_m : tmo_m);
        chk("R2 read err", {31'd0, er}, 32'd0);
    endtask

    task automatic do_bad(input logic wr, input logic [31:0] a);
        logic [31:0] rd; logic er, rdy, srdy;
        bus_op(wr, a, $urandom, rd, er, rdy, srdy);
        chk("R9 bad err", {31'd0, er}, 32'd1);
        chk("R9 bad rdata", rd, 32'd0);
        check_flags("R9 no state change");
        chk("R9 cfg kept", {clk_divider, xmit_en, recv_en}, {cfg_m[31:2], exp_xmit(cfg_m), exp_recv(cfg_m)});
        chk("R9 delay kept", start_delay, tmo_m);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] bad_addrs [6];
        logic [31:0] rd; logic er, rdy, srdy;
        bad_addrs = '{32'd16, 32'd2, 32'd5, 32'h100, 32'hFFFF_FFFC, 32'd13};
        void'($urandom(SEED));
        rst_n = 1'b0; apb_sel = 0; apb_enable = 0; apb_write = 0;
        apb_addr = '0; apb_wdata = '0; tx_pop = 0; rx_push = 0; rx_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq_tx_empty", {31'd0, irq_tx_empty}, 32'd1);
        chk("R1 irq_rx_avail", {31'd0, irq_rx_avail}, 32'd0);
        chk("R1 start_delay", start_delay, 32'd0);
        chk("R1 divider", {2'b00, clk_divider}, 32'd0);
        chk("R2 idle ready", {30'd0, apb_ready, apb_err}, 32'd0);
        do_reg_read(32'd8);
        do_reg_read(32'd12);

        // R3 setup-only cycle has no effect
        @(negedge clk);
        apb_sel = 1'b1; apb_enable = 1'b0; apb_write = 1'b1; apb_addr = 32'd0; apb_wdata = 32'hDEAD_0001;
        @(negedge clk);
        apb_sel = 1'b0;
        chk("R3 setup only", {31'd0, irq_tx_empty}, 32'd1);

        // R3 R4 fill transmit queue past full, then drain in order
        for (int i = 0; i < TXD + 2; i++) do_tx_write(32'hA000_0000 + i);
        check_flags("R10 tx full");
        for (int i = 0; i < TXD + 1; i++) do_eng_pop();
        check_flags("R10 tx drained");

        // R5 R6 R11 receive side to full and beyond
        do_rx_read();
        for (int i = 0; i < RXD + 2; i++) do_eng_push(32'hB000_0000 + i);
        check_flags("R11 rx full");
        for (int i = 0; i < RXD + 1; i++) do_rx_read();

        // R7 operation codes
        do_reg_write(32'd8, {30'd10, 2'b01});
        do_reg_write(32'd8, {30'd77, 2'b10});
        do_reg_write(32'd8, {30'h3FFF_FFFF, 2'b11});
        do_reg_write(32'd8, {30'd5, 2'b00});
        do_reg_write(32'd12, 32'd10000);
        do_reg_read(32'd8);
        do_reg_read(32'd12);

        // R9 illegal accesses
        foreach (bad_addrs[k]) begin
            do_bad(1'b1, bad_addrs[k]);
            do_bad(1'b0, bad_addrs[k]);
        end
        do_eng_push(32'h1234_5678);
        do_bad(1'b1, 32'd4);
        do_tx_write(32'h5555_AAAA);
        do_bad(1'b0, 32'd0);
        do_rx_read();
        do_eng_pop();

        // random mix
        for (int n = 0; n < 600; n++) begin
            case ($urandom_range(0, 8))
                0, 1: do_tx_write($urandom);
                2, 3: do_rx_read();
                4:    do_eng_pop();
                5:    do_eng_push($urandom);
                6:    do_reg_write(($urandom_range(0, 1) != 0) ? 32'd8 : 32'd12, $urandom);
                7:    do_reg_read(($urandom_range(0, 1) != 0) ? 32'd8 : 32'd12);
                default: do_bad($urandom_range(0, 1) != 0, bad_addrs[$urandom_range(0, 5)]);
            endcase
            check_flags("R10 flags");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule